// File: doc/BRIEF.md
# Exception Entry Vector Controller

This block works out the processor state change when an exception is taken. A single-cycle request carries the exception kind, the PC of the faulting instruction, a flag that says whether that instruction sits in a branch-delay slot, and a TLB no-match flag. The current status bits, the interrupt pending and mask bits, the vectored-interrupt enable, the vector spacing and the exception base register also come in as inputs.

One cycle after the request, the block presents four things. The first is the handler address. The second is the saved return addresses: the exception PC for ordinary exceptions and the error PC for the error-level path. The third is the branch-delay flag. The fourth is the 5-bit cause code together with the next values of the status bits.

When there is no request, the status outputs follow the status inputs with one cycle of delay, and the captured registers hold their values. The status owner in the surrounding core can therefore use the status outputs as the next value of its status register.

Ordinary exceptions enter at exception level. NMI and reset instead take the error-level path to the fixed boot vector.

Top module: `exc_entry_vec`

## Requirements
- R1: After reset, the outputs are: pc_o = 0xBFC00000, exl_o = 0, erl_o = 1, bev_o = 1, nmi_o = 0, ksu_o = 0, epc_o = 0, err_epc_o = 0, bd_o = 0, code_o = 0 and upd_o = 0.
- R2: A general request (any kind except 28 and 29) with exl_i = 0 loads epc_o with pc_i, or with pc_i - 4 when in_slot_i = 1. It sets bd_o equal to in_slot_i and sets exl_o to 1.
- R3: A general request with exl_i = 1 leaves epc_o and bd_o unchanged. It still writes code_o, and exl_o stays 1.
- R4: A general request writes code_o = kind_i. The codes are: 0 interrupt, 1 TLB modify, 2 TLB load, 3 TLB store, 4 address error on load, 5 address error on store, 6 instruction bus error, 7 data bus error, 8 syscall, 9 break, 10 reserved instruction, 11 coprocessor unusable, 12 overflow, 13 trap, 30 cache error. Kind 28 is NMI and kind 29 is reset. code_o is the field at cause bits 6:2.
- R5: The handler base for a general request is 0xBFC00200 when bev_i = 1. Otherwise it is ebase_i with bits 9:0 cleared. The default offset is 0x180, and pc_o = base + offset.
- R6: Kind 2 or 3 with tlb_miss_i = 1 and exl_i = 0 uses offset 0x000. With exl_i = 1, the offset is 0x180.
- R7: For kind 0 with iv_i = 0, the offset is 0x180. With iv_i = 1, the offset is 0x200 when bev_i = 1 or spacing_i = 0. Otherwise the offset is 0x200 + v × spacing_i × 32, where v is the index of the highest set bit of (ip_i AND im_i), or 0 when no bit is set.
- R8: Kind 30 uses offset 0x100 when bev_i = 1 and 0x20000100 when bev_i = 0.
- R9: An error-level request (kind 28 or 29) gives the following results:
  - pc_o = 0xBFC00000.
  - err_epc_o = pc_i, or pc_i - 4 when in delay slot.
  - erl_o = 1, bev_o = 1, exl_o = exl_i.
  - epc_o, bd_o and code_o are unchanged.
- R10: Kind 28 sets nmi_o to 1, and kind 29 clears nmi_o. A general request passes nmi_i through to nmi_o.
- R11: Every request drives ksu_o to 0 and raises upd_o for exactly the following cycle.
- R12: When there is no request, the following hold in the next cycle:
  - exl_o, erl_o, bev_o, nmi_o and ksu_o equal the previous cycle's inputs.
  - pc_o, epc_o, err_epc_o, bd_o and code_o hold.
  - upd_o = 0.
  
  A general request passes erl_i and bev_i through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Exception request, one cycle |
| kind_i | input | 5 | Exception kind (see R4) |
| tlb_miss_i | input | 1 | TLB lookup found no entry |
| pc_i | input | 32 | PC of the faulting instruction |
| in_slot_i | input | 1 | Faulting instruction is in a delay slot |
| exl_i | input | 1 | Current exception-level bit |
| erl_i | input | 1 | Current error-level bit |
| bev_i | input | 1 | Current boot-vector select bit |
| nmi_i | input | 1 | Current NMI status bit |
| ksu_i | input | 2 | Current privilege-mode bits |
| im_i | input | 8 | Interrupt mask |
| ip_i | input | 8 | Interrupt pending |
| iv_i | input | 1 | Vectored interrupt enable |
| spacing_i | input | 5 | Vector spacing in 32-byte units |
| ebase_i | input | 32 | Exception base register |
| upd_o | output | 1 | Outputs updated by a request |
| pc_o | output | 32 | Handler address |
| epc_o | output | 32 | Exception return address |
| err_epc_o | output | 32 | Error-level return address |
| bd_o | output | 1 | Branch-delay flag |
| code_o | output | 5 | Cause code |
| exl_o | output | 1 | Next exception-level bit |
| erl_o | output | 1 | Next error-level bit |
| bev_o | output | 1 | Next boot-vector select bit |
| nmi_o | output | 1 | Next NMI status bit |
| ksu_o | output | 2 | Next privilege-mode bits |

## Verification
The bench aims at the following corner cases, each of which has a specific failure signature:
- **Nested exception with EXL already set.** A design that recaptures EPC here would overwrite the original return address.
- **Refill fault under EXL.** A design that ignores EXL would jump to offset 0 instead of 0x180.
- **Vectored interrupts with zero spacing, BEV set, or no enabled pending line.** A wrong priority encoder or wrong spacing scale moves the handler by multiples of 32 bytes.
- **Cache errors.** A design that forgets the BEV split lands 0x20000000 off.
- **Error-level path.** A design that wrongly touches EPC, BD or the cause code, or that fails to set ERL and BEV, shows up as a mismatch.
- **Delay-slot requests.** These catch a missing 4-byte adjustment in both return registers.

// File: rtl/exc_entry_vec.sv
module exc_entry_vec #(
  parameter int AW = 32,
  parameter logic [AW-1:0] BOOT_BASE = 'hBFC0_0000,
  parameter int IRQ_N = 8,
  parameter int CODE_W = 5,
  parameter int SP_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic [CODE_W-1:0] kind_i,
  input  logic              tlb_miss_i,
  input  logic [AW-1:0]     pc_i,
  input  logic              in_slot_i,
  input  logic              exl_i,
  input  logic              erl_i,
  input  logic              bev_i,
  input  logic              nmi_i,
  input  logic [1:0]        ksu_i,
  input  logic [IRQ_N-1:0]  im_i,
  input  logic [IRQ_N-1:0]  ip_i,
  input  logic              iv_i,
  input  logic [SP_W-1:0]   spacing_i,
  input  logic [AW-1:0]     ebase_i,
  output logic              upd_o,
  output logic [AW-1:0]     pc_o,
  output logic [AW-1:0]     epc_o,
  output logic [AW-1:0]     err_epc_o,
  output logic              bd_o,
  output logic [CODE_W-1:0] code_o,
  output logic              exl_o,
  output logic              erl_o,
  output logic              bev_o,
  output logic              nmi_o,
  output logic [1:0]        ksu_o
);
  localparam int VEC_W = (IRQ_N > 1) ? $clog2(IRQ_N) : 1;
  localparam logic [CODE_W-1:0] K_INT  = CODE_W'(0);
  localparam logic [CODE_W-1:0] K_TLBL = CODE_W'(2);
  localparam logic [CODE_W-1:0] K_TLBS = CODE_W'(3);
  localparam logic [CODE_W-1:0] K_NMI  = CODE_W'(28);
  localparam logic [CODE_W-1:0] K_RST  = CODE_W'(29);
  localparam logic [CODE_W-1:0] K_CERR = CODE_W'(30);
  localparam logic [AW-1:0] OFF_GEN  = AW'('h180);
  localparam logic [AW-1:0] OFF_VEC  = AW'('h200);
  localparam logic [AW-1:0] OFF_CEB  = AW'('h100);
  localparam logic [AW-1:0] OFF_CEN  = AW'('h2000_0100);

  logic              is_err, is_gen;
  logic [IRQ_N-1:0]  act;
  logic [VEC_W-1:0]  vec;
  logic [AW-1:0]     off, base, slot_pc;

  assign is_err  = req_i && (kind_i == K_NMI || kind_i == K_RST);
  assign is_gen  = req_i && !is_err;
  assign act     = ip_i & im_i;
  assign slot_pc = in_slot_i ? pc_i - AW'(4) : pc_i;
  assign base    = bev_i ? BOOT_BASE + OFF_VEC : {ebase_i[AW-1:10], 10'b0};

  always_comb begin
    vec = '0;
    for (int i = 0; i < IRQ_N; i++)
      if (act[i]) vec = VEC_W'(i);
  end

  always_comb begin
    off = OFF_GEN;
    if (kind_i == K_INT && iv_i) begin
      if (bev_i || spacing_i == '0) off = OFF_VEC;
      else off = OFF_VEC + AW'(vec) * (AW'(spacing_i) << 5);
    end else if ((kind_i == K_TLBL || kind_i == K_TLBS) && tlb_miss_i && !exl_i) begin
      off = '0;
    end else if (kind_i == K_CERR) begin
      off = bev_i ? OFF_CEB : OFF_CEN;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      upd_o     <= 1'b0;
      pc_o      <= BOOT_BASE;
      epc_o     <= '0;
      err_epc_o <= '0;
      bd_o      <= 1'b0;
      code_o    <= '0;
      exl_o     <= 1'b0;
      erl_o     <= 1'b1;
      bev_o     <= 1'b1;
      nmi_o     <= 1'b0;
      ksu_o     <= 2'b00;
    end else begin
      upd_o <= req_i;
      exl_o <= exl_i;
      erl_o <= erl_i;
      bev_o <= bev_i;
      nmi_o <= nmi_i;
      ksu_o <= req_i ? 2'b00 : ksu_i;
      if (is_gen) begin
        pc_o   <= base + off;
        code_o <= kind_i;
        exl_o  <= 1'b1;
        if (!exl_i) begin
          epc_o <= slot_pc;
          bd_o  <= in_slot_i;
        end
      end else if (is_err) begin
        pc_o      <= BOOT_BASE;
        err_epc_o <= slot_pc;
        erl_o     <= 1'b1;
        bev_o     <= 1'b1;
        nmi_o     <= (kind_i == K_NMI);
      end
    end
  end
endmodule

// File: rtl/exc_entry_vec_chk.sv
module exc_entry_vec_chk #(
  parameter int AW = 32,
  parameter logic [AW-1:0] BOOT_BASE = 'hBFC0_0000,
  parameter int CODE_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_i,
  input logic [CODE_W-1:0] kind_i,
  input logic              exl_i,
  input logic              erl_i,
  input logic              bev_i,
  input logic              upd_o,
  input logic [AW-1:0]     pc_o,
  input logic [AW-1:0]     epc_o,
  input logic              bd_o,
  input logic [CODE_W-1:0] code_o,
  input logic              exl_o,
  input logic              erl_o,
  input logic              bev_o,
  input logic [1:0]        ksu_o
);
  logic err_k;
  assign err_k = (kind_i == CODE_W'(28)) || (kind_i == CODE_W'(29));

  AST_GEN_SETS_EXL: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !err_k) |=> exl_o); // R2
  AST_NESTED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !err_k && exl_i) |=> ($stable(epc_o) && $stable(bd_o))); // R3
  AST_GEN_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !err_k) |=> (code_o == $past(kind_i))); // R4
  AST_ERR_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && err_k) |=> (pc_o == BOOT_BASE && erl_o && bev_o)); // R9
  AST_ERR_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && err_k) |=> ($stable(code_o) && $stable(epc_o) && $stable(bd_o))); // R9
  AST_KERNEL: assert property (@(posedge clk) disable iff (!rst_n)
    req_i |=> (ksu_o == 2'b00 && upd_o)); // R11
  AST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> (!upd_o && $stable(pc_o) && exl_o == $past(exl_i))); // R12
  AST_GEN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !err_k) |=> (erl_o == $past(erl_i) && bev_o == $past(bev_i))); // R12
endmodule

bind exc_entry_vec exc_entry_vec_chk #(.AW(AW), .BOOT_BASE(BOOT_BASE), .CODE_W(CODE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_i(req_i), .kind_i(kind_i), .exl_i(exl_i),
  .erl_i(erl_i), .bev_i(bev_i), .upd_o(upd_o), .pc_o(pc_o), .epc_o(epc_o),
  .bd_o(bd_o), .code_o(code_o), .exl_o(exl_o), .erl_o(erl_o), .bev_o(bev_o),
  .ksu_o(ksu_o)
);

// File: tb/exc_entry_vec_tb_top.sv
module exc_entry_vec_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic req, miss, slot, exl, erl, bev, nmi, iv;
  logic [4:0] kind, sp;
  logic [1:0] ksu;
  logic [7:0] im, ip;
  logic [31:0] pc, eb;
  logic upd_o, bd_o, exl_o, erl_o, bev_o, nmi_o;
  logic [31:0] pc_o, epc_o, err_epc_o;
  logic [4:0] code_o;
  logic [1:0] ksu_o;

  exc_entry_vec dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req), .kind_i(kind), .tlb_miss_i(miss),
    .pc_i(pc), .in_slot_i(slot), .exl_i(exl), .erl_i(erl), .bev_i(bev),
    .nmi_i(nmi), .ksu_i(ksu), .im_i(im), .ip_i(ip), .iv_i(iv),
    .spacing_i(sp), .ebase_i(eb), .upd_o(upd_o), .pc_o(pc_o), .epc_o(epc_o),
    .err_epc_o(err_epc_o), .bd_o(bd_o), .code_o(code_o), .exl_o(exl_o),
    .erl_o(erl_o), .bev_o(bev_o), .nmi_o(nmi_o), .ksu_o(ksu_o)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] m_pc = 32'hBFC0_0000, m_epc = 0, m_eepc = 0;
  logic m_bd = 0;
  logic [4:0] m_code = 0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_pc(logic [4:0] k, logic ms, logic ex, logic bv,
      logic v_en, logic [7:0] p, logic [7:0] m, logic [4:0] s, logic [31:0] e);
    logic [31:0] b, o;
    int hi;
    if (k == 5'd28 || k == 5'd29) return 32'hBFC0_0000;
    b = bv ? 32'hBFC0_0200 : (e & ~32'h3FF);
    o = 32'h180;
    if (k == 5'd0 && v_en) begin
      if (bv || s == 0) o = 32'h200;
      else begin
        hi = 0;
        for (int i = 0; i < 8; i++) if (p[i] & m[i]) hi = i;
        o = 32'h200 + 32'(hi) * 32'(s) * 32;
      end
    end else if ((k == 5'd2 || k == 5'd3) && ms && !ex) o = 0;
    else if (k == 5'd30) o = bv ? 32'h100 : 32'h2000_0100;
    return b + o;
  endfunction

  task automatic step(logic r, logic [4:0] k, logic ms, logic [31:0] p_c, logic sl,
      logic ex, logic er, logic bv, logic nm, logic [1:0] ks, logic v_en,
      logic [7:0] p, logic [7:0] m, logic [4:0] s, logic [31:0] e);
    logic err, e_exl, e_erl, e_bev, e_nmi;
    logic [1:0] e_ksu;
    string ptag;
    @(negedge clk);
    req = r; kind = k; miss = ms; pc = p_c; slot = sl; exl = ex; erl = er;
    bev = bv; nmi = nm; ksu = ks; iv = v_en; ip = p; im = m; sp = s; eb = e;
    err = (k == 5'd28 || k == 5'd29);
    e_exl = ex; e_erl = er; e_bev = bv; e_nmi = nm; e_ksu = r ? 2'b00 : ks;
    ptag = "R5";
    if (r && !err) begin
      m_pc = model_pc(k, ms, ex, bv, v_en, p, m, s, e);
      m_code = k;
      e_exl = 1'b1;
      if (!ex) begin m_epc = sl ? p_c - 4 : p_c; m_bd = sl; end
      if (k == 5'd0) ptag = "R7";
      else if ((k == 5'd2 || k == 5'd3) && ms) ptag = "R6";
      else if (k == 5'd30) ptag = "R8";
    end else if (r) begin
      m_pc = 32'hBFC0_0000;
      m_eepc = sl ? p_c - 4 : p_c;
      e_erl = 1'b1; e_bev = 1'b1; e_nmi = (k == 5'd28);
      ptag = "R9";
    end
    @(negedge clk);
    req = 1'b0;
    if (!r) ptag = "R12";
    check(ptag, pc_o, m_pc);
    check(ex ? "R3 epc" : "R2 epc", epc_o, m_epc);
    check(ex ? "R3 bd" : "R2 bd", 32'(bd_o), 32'(m_bd));
    check("R9 err_epc", err_epc_o, m_eepc);
    check("R4 code", 32'(code_o), 32'(m_code));
    check("R2 exl", 32'(exl_o), 32'(e_exl));
    check("R12 erl", 32'(erl_o), 32'(e_erl));
    check("R12 bev", 32'(bev_o), 32'(e_bev));
    check("R10 nmi", 32'(nmi_o), 32'(e_nmi));
    check("R11 ksu", 32'(ksu_o), 32'(e_ksu));
    check("R11 upd", 32'(upd_o), 32'(r));
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    req = 0; kind = 0; miss = 0; pc = 0; slot = 0; exl = 0; erl = 1; bev = 1;
    nmi = 0; ksu = 0; iv = 0; ip = 0; im = 0; sp = 0; eb = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state (req held low, inputs equal reset values)
    check("R1 pc", pc_o, 32'hBFC0_0000);
    check("R1 epc", epc_o, 0);
    check("R1 erl_bev", {30'd0, erl_o, bev_o}, 32'd3);
    check("R1 others", {20'd0, exl_o, nmi_o, ksu_o, bd_o, code_o, upd_o, err_epc_o[0]}, 0);
    // R2 syscall from delay slot, ebase path
    step(1, 5'd8, 0, 32'h8000_1000, 1, 0, 0, 0, 0, 2'b10, 0, 0, 0, 0, 32'h8123_45FF);
    // R3 nested break: EPC/BD keep, code updated
    step(1, 5'd9, 0, 32'h8000_2000, 0, 1, 0, 0, 0, 2'b00, 0, 0, 0, 0, 32'h8000_0000);
    // R6 refill with EXL clear, then with EXL set
    step(1, 5'd2, 1, 32'h0040_0000, 0, 0, 0, 0, 0, 2'b10, 0, 0, 0, 0, 32'h8000_0000);
    step(1, 5'd3, 1, 32'h0040_0004, 0, 1, 0, 1, 0, 2'b10, 0, 0, 0, 0, 32'h8000_0000);
    // R7 interrupt variants
    step(1, 5'd0, 0, 32'h100, 0, 0, 0, 0, 0, 0, 1, 8'hFF, 8'h28, 5'd3, 32'h8000_0000);
    step(1, 5'd0, 0, 32'h104, 0, 0, 0, 0, 0, 0, 1, 8'hFF, 8'hFF, 5'd0, 32'h8000_0000);
    step(1, 5'd0, 0, 32'h108, 0, 0, 0, 1, 0, 0, 1, 8'hFF, 8'hFF, 5'd4, 32'h8000_0000);
    step(1, 5'd0, 0, 32'h10C, 0, 0, 0, 0, 0, 0, 1, 8'h0F, 8'hF0, 5'd2, 32'h8000_0000);
    step(1, 5'd0, 0, 32'h110, 0, 0, 0, 0, 0, 0, 0, 8'hFF, 8'hFF, 5'd2, 32'h8000_0000);
    // R8 cache error both BEV settings
    step(1, 5'd30, 0, 32'h200, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 32'h9000_0000);
    step(1, 5'd30, 0, 32'h204, 0, 1, 0, 1, 0, 0, 0, 0, 0, 0, 32'h9000_0000);
    // R9 R10 NMI from slot, then reset
    step(1, 5'd28, 0, 32'h300, 1, 0, 0, 0, 0, 2'b10, 0, 0, 0, 0, 32'h9000_0000);
    step(1, 5'd29, 0, 32'h400, 0, 1, 0, 0, 1, 2'b01, 0, 0, 0, 0, 32'h9000_0000);
    // R12 idle tracking
    step(0, 5'd8, 0, 32'h500, 1, 0, 1, 0, 1, 2'b11, 0, 0, 0, 0, 32'h9000_0000);
    for (int t = 0; t < 400; t++) begin
      logic [4:0] k;
      k = ($urandom % 4 == 0) ? 5'(28 + $urandom % 3) : 5'($urandom % 14);
      step(($urandom % 5) != 0, k, 1'($urandom), $urandom & ~32'h3, 1'($urandom),
           1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 2'($urandom),
           1'($urandom), 8'($urandom), 8'($urandom), 5'($urandom), $urandom);
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule